// File: doc/BRIEF.md
# Aligned Load/Store Access Unit

This unit carries out the memory-access instructions of a 64-bit register virtual machine. The execute stage hands it one request at a time: an opcode byte, the value of the base register, a signed 16-bit displacement and, for stores, the source register value. The unit decodes the opcode into a direction and an access width of one, two, four or eight bytes. It adds the sign-extended displacement to the base to form a byte address, and checks that the address is a multiple of the access width.

An aligned request drives a synchronous memory port in the same cycle. The port is a doubleword wide, carries the full byte address, and has one strobe per byte lane. A load returns its result one cycle later with a valid pulse: the addressed bytes, moved down to bit 0 and zero-extended. A store drives only the lanes it writes, puts the low bytes of the source in those lanes, and answers with a done pulse one cycle later.

A misaligned address or an unknown opcode never reaches memory. Each one answers with its own trap pulse one cycle after the request, which the pipeline uses to abort execution.

Top module: `lsu_top`

## Requirements
- R1: Opcode 0x71 is a 1-byte load, 0x69 a 2-byte load, 0x61 a 4-byte load and 0x79 an 8-byte load.
- R2: Opcode 0x73 is a 1-byte store, 0x6b a 2-byte store, 0x63 a 4-byte store and 0x7b an 8-byte store.
- R3: The address driven on memAddr is reqBase plus reqOffset sign-extended to 64 bits, wrapping modulo 2^64.
- R4: Memory is little-endian: byte lane k of the doubleword holds bits 8k+7:8k and maps to address bits [2:0] equal to k. A load returns the addressed bytes in the low bits of loadData, and the bits above the access width are zero.
- R5: A store asserts memStrb exactly on lanes addr[2:0] through addr[2:0]+width-1. It places byte j of reqStoreData in lane addr[2:0]+j for every j below the width.
- R6: A 2-, 4- or 8-byte access whose address is not a multiple of its width leaves memEn low and pulses trapMisaligned in the next cycle. A 1-byte access is never misaligned.
- R7: Any opcode other than the eight above leaves memEn low and pulses trapIllegal in the next cycle, whatever the address.
- R8: An aligned load pulses loadValid in the cycle after the request, and an aligned store pulses storeDone in the cycle after the request.
- R9: Each request yields exactly one of loadValid, storeDone, trapMisaligned and trapIllegal. After reset all four are low and memEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 8 | Instruction opcode byte |
| reqBase | input | 64 | Base register value |
| reqOffset | input | 16 | Signed displacement |
| reqStoreData | input | 64 | Store source register value |
| memEn | output | 1 | Memory access this cycle |
| memWe | output | 1 | Access is a write |
| memAddr | output | 64 | Byte address of the access |
| memStrb | output | 8 | Byte-lane enables |
| memWdata | output | 64 | Write data, lane-positioned |
| memRdata | input | 64 | Read doubleword, valid the cycle after a read |
| loadValid | output | 1 | Load result valid pulse |
| loadData | output | 64 | Zero-extended load result |
| storeDone | output | 1 | Store completion pulse |
| trapMisaligned | output | 1 | Misaligned-access trap pulse |
| trapIllegal | output | 1 | Unknown-opcode trap pulse |

## Verification
The assertions assume that the memory returns the doubleword holding the read address exactly one cycle after memEn with memWe low. They also assume that a request is held for a single cycle and never issued back-to-back with another. The bench keeps to both rules: its memory model registers reads on the clock edge, and it leaves an idle cycle after every request. Random requests use addresses inside a 256-byte window, formed from a random target address and a random signed displacement. The base is derived from the two, so wrapping arithmetic is exercised without leaving the modelled memory. Directed cases add the displacement extremes, an address that wraps through zero, every misalignment of each width, and opcodes next to the legal ones.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } accSize_e;

  typedef struct packed {
    logic memEn;
    logic memWe;
    logic captureLoad;
  } ctrlStrobes_t;

  localparam logic [7:0] OP_LD_B = 8'h71;
  localparam logic [7:0] OP_LD_H = 8'h69;
  localparam logic [7:0] OP_LD_W = 8'h61;
  localparam logic [7:0] OP_LD_D = 8'h79;
  localparam logic [7:0] OP_ST_B = 8'h73;
  localparam logic [7:0] OP_ST_H = 8'h6b;
  localparam logic [7:0] OP_ST_W = 8'h63;
  localparam logic [7:0] OP_ST_D = 8'h7b;
endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
#(
  parameter int LANE_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [7:0]           reqOp,
  input  logic [LANE_BITS-1:0] eaLow,
  output ctrlStrobes_t         strobes,
  output accSize_e             accSize,
  output logic                 loadValid,
  output logic                 storeDone,
  output logic                 trapMisaligned,
  output logic                 trapIllegal
);
  logic opLegal, opStore, addrAligned;
  logic [LANE_BITS-1:0] alignMask;

  always_comb begin
    opLegal = 1'b1;
    opStore = 1'b0;
    accSize = SZ_BYTE;
    unique case (reqOp)
      OP_LD_B: accSize = SZ_BYTE;
      OP_LD_H: accSize = SZ_HALF;
      OP_LD_W: accSize = SZ_WORD;
      OP_LD_D: accSize = SZ_DBL;
      OP_ST_B: begin accSize = SZ_BYTE; opStore = 1'b1; end
      OP_ST_H: begin accSize = SZ_HALF; opStore = 1'b1; end
      OP_ST_W: begin accSize = SZ_WORD; opStore = 1'b1; end
      OP_ST_D: begin accSize = SZ_DBL;  opStore = 1'b1; end
      default: opLegal = 1'b0;
    endcase
  end

  always_comb begin
    alignMask = LANE_BITS'((1 << accSize) - 1);
    addrAligned = (eaLow & alignMask) == '0;
  end

  always_comb begin
    strobes.memEn       = reqValid && opLegal && addrAligned;
    strobes.memWe       = strobes.memEn && opStore;
    strobes.captureLoad = strobes.memEn && !opStore;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadValid      <= 1'b0;
      storeDone      <= 1'b0;
      trapMisaligned <= 1'b0;
      trapIllegal    <= 1'b0;
    end else begin
      loadValid      <= strobes.captureLoad;
      storeDone      <= strobes.memWe;
      trapMisaligned <= reqValid && opLegal && !addrAligned;
      trapIllegal    <= reqValid && !opLegal;
    end
  end

  p_illegal_no_access_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !opLegal) |-> (!strobes.memEn ##1 trapIllegal));

  p_misalign_trap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opLegal && accSize != SZ_BYTE && eaLow[0]) |=> trapMisaligned);

  p_byte_never_misaligned_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opLegal && accSize == SZ_BYTE) |=> !trapMisaligned);

  p_load_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureLoad |=> (loadValid && !storeDone));

  p_store_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.memWe |=> (storeDone && !loadValid));

  p_one_response_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadValid, storeDone, trapMisaligned, trapIllegal}));

  p_response_needs_request_r9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !(loadValid || storeDone || trapMisaligned || trapIllegal));
endmodule

// File: rtl/lsu_datapath.sv
module lsu_datapath
  import lsu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 16,
  localparam int LANES     = DATA_W / 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  accSize_e             accSize,
  input  logic [ADDR_W-1:0]    reqBase,
  input  logic [OFF_W-1:0]     reqOffset,
  input  logic [DATA_W-1:0]    reqStoreData,
  output logic [LANE_BITS-1:0] eaLow,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [LANES-1:0]     memStrb,
  output logic [DATA_W-1:0]    memWdata,
  input  logic [DATA_W-1:0]    memRdata,
  output logic [DATA_W-1:0]    loadData
);
  logic [ADDR_W-1:0]    effAddr;
  logic [LANES-1:0]     sizeLanes;
  logic [LANE_BITS-1:0] laneQ;
  accSize_e             sizeQ;
  logic [DATA_W-1:0]    shiftedRd;
  logic [DATA_W-1:0]    keepMask;

  assign effAddr = reqBase + {{(ADDR_W-OFF_W){reqOffset[OFF_W-1]}}, reqOffset};
  assign eaLow   = effAddr[LANE_BITS-1:0];
  assign memAddr = effAddr;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign sizeLanes[g] = (g < (1 << accSize));
    end
  endgenerate

  assign memStrb  = strobes.memWe ? (sizeLanes << eaLow) : '0;
  assign memWdata = reqStoreData << {eaLow, 3'b000};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laneQ <= '0;
      sizeQ <= SZ_BYTE;
    end else if (strobes.captureLoad) begin
      laneQ <= eaLow;
      sizeQ <= accSize;
    end
  end

  always_comb begin
    shiftedRd = memRdata >> {laneQ, 3'b000};
    unique case (sizeQ)
      SZ_BYTE: keepMask = DATA_W'({8{1'b1}});
      SZ_HALF: keepMask = DATA_W'({16{1'b1}});
      SZ_WORD: keepMask = DATA_W'({32{1'b1}});
      default: keepMask = '1;
    endcase
    loadData = shiftedRd & keepMask;
  end

  p_strobe_width_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.memWe |-> ($countones(memStrb) == (1 << accSize)));

  p_no_read_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.memEn && !strobes.memWe) |-> (memStrb == '0));

  p_access_aligned_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.memEn |-> ((memAddr[LANE_BITS-1:0] & LANE_BITS'((1 << accSize) - 1)) == '0));

  p_zero_ext_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.captureLoad && accSize == SZ_BYTE) |=> (loadData[DATA_W-1:8] == '0));
endmodule

// File: rtl/lsu_top.sv
module lsu_top
  import lsu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 16,
  localparam int LANES     = DATA_W / 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [7:0]        reqOp,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [DATA_W-1:0] reqStoreData,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memStrb,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              loadValid,
  output logic [DATA_W-1:0] loadData,
  output logic              storeDone,
  output logic              trapMisaligned,
  output logic              trapIllegal
);
  ctrlStrobes_t         strobes;
  accSize_e             accSize;
  logic [LANE_BITS-1:0] eaLow;

  lsu_ctrl #(.LANE_BITS(LANE_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .eaLow(eaLow),
    .strobes(strobes), .accSize(accSize), .loadValid(loadValid),
    .storeDone(storeDone), .trapMisaligned(trapMisaligned), .trapIllegal(trapIllegal)
  );

  lsu_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .accSize(accSize),
    .reqBase(reqBase), .reqOffset(reqOffset), .reqStoreData(reqStoreData),
    .eaLow(eaLow), .memAddr(memAddr), .memStrb(memStrb), .memWdata(memWdata),
    .memRdata(memRdata), .loadData(loadData)
  );

  assign memEn = strobes.memEn;
  assign memWe = strobes.memWe;

  p_reset_quiet_r9: assert property (@(posedge clk)
    !rstN |=> !(loadValid || storeDone || trapMisaligned || trapIllegal));
endmodule

// File: tb/lsu_top_bench.sv
module lsu_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [7:0]  reqOp = 8'h00;
  logic [63:0] reqBase = '0;
  logic [15:0] reqOffset = '0;
  logic [63:0] reqStoreData = '0;
  logic        memEn, memWe, loadValid, storeDone, trapMisaligned, trapIllegal;
  logic [63:0] memAddr, memWdata, loadData;
  logic [7:0]  memStrb;
  logic [63:0] memRdata = '0;

  logic [7:0] ram [0:255];
  logic [7:0] shadow [0:255];
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  lsu_top u_lsu_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqBase(reqBase),
    .reqOffset(reqOffset), .reqStoreData(reqStoreData), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memStrb(memStrb), .memWdata(memWdata), .memRdata(memRdata),
    .loadValid(loadValid), .loadData(loadData), .storeDone(storeDone),
    .trapMisaligned(trapMisaligned), .trapIllegal(trapIllegal)
  );

  // Doubleword-wide synchronous memory over a 256-byte window
  always @(posedge clk) begin
    if (memEn) begin
      for (int k = 0; k < 8; k++) begin
        if (memWe && memStrb[k]) ram[{memAddr[7:3], 3'(k)}] <= memWdata[8*k +: 8];
        if (!memWe) memRdata[8*k +: 8] <= ram[{memAddr[7:3], 3'(k)}];
      end
    end
  end

  function automatic int opBytes(input logic [7:0] op);
    case (op)
      8'h71, 8'h73: return 1;
      8'h69, 8'h6b: return 2;
      8'h61, 8'h63: return 4;
      8'h79, 8'h7b: return 8;
      default:      return 0;
    endcase
  endfunction

  function automatic bit opIsStore(input logic [7:0] op);
    return (op == 8'h73) || (op == 8'h6b) || (op == 8'h63) || (op == 8'h7b);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doReq(input logic [7:0] op, input logic [63:0] base,
                       input logic [15:0] off, input logic [63:0] sdata);
    logic [63:0] ea, expLoad, expStrb;
    int n;
    bit st, legal, aligned;
    string rq;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqBase = base; reqOffset = off; reqStoreData = sdata;
    ea = base + {{48{off[15]}}, off};
    n = opBytes(op);
    legal = (n != 0);
    st = opIsStore(op);
    aligned = legal && ((ea % n) == 0);
    rq = st ? "R2" : "R1";
    #1;
    if (!legal) begin
      check(!memEn, "R7", "memEn on illegal opcode", {63'd0, memEn}, 64'd0);
    end else if (!aligned) begin
      check(!memEn, "R6", "memEn on misaligned", {63'd0, memEn}, 64'd0);
    end else begin
      check(memEn && (memWe == st), rq, "memEn/memWe decode", {62'd0, memEn, memWe}, {62'd0, 1'b1, st});
      check(memAddr == ea, "R3", "effective address", memAddr, ea);
      if (st) begin
        expStrb = ((64'd1 << n) - 1) << ea[2:0];
        check(memStrb == expStrb[7:0], "R5", "store strobes", {56'd0, memStrb}, expStrb);
        for (int j = 0; j < n; j++) begin
          check(memWdata[8*(ea[2:0]+j) +: 8] == sdata[8*j +: 8], "R5", "store lane data",
                {56'd0, memWdata[8*(ea[2:0]+j) +: 8]}, {56'd0, sdata[8*j +: 8]});
          shadow[ea[7:0] + 8'(j)] = sdata[8*j +: 8];
        end
      end
    end
    @(negedge clk);
    reqValid = 1'b0;
    if (!legal) begin
      check(trapIllegal && !trapMisaligned && !loadValid && !storeDone, "R7", "illegal trap response",
            {60'd0, loadValid, storeDone, trapMisaligned, trapIllegal}, 64'h1);
    end else if (!aligned) begin
      check(trapMisaligned && !trapIllegal && !loadValid && !storeDone, "R6", "misaligned trap response",
            {60'd0, loadValid, storeDone, trapMisaligned, trapIllegal}, 64'h2);
    end else if (st) begin
      check(storeDone && !loadValid && !trapMisaligned && !trapIllegal, "R8", "store done pulse",
            {60'd0, loadValid, storeDone, trapMisaligned, trapIllegal}, 64'h4);
    end else begin
      expLoad = '0;
      for (int j = 0; j < n; j++) expLoad[8*j +: 8] = shadow[ea[7:0] + 8'(j)];
      check(loadValid && !storeDone && !trapMisaligned && !trapIllegal, "R8", "load valid pulse",
            {60'd0, loadValid, storeDone, trapMisaligned, trapIllegal}, 64'h8);
      check(loadData == expLoad, "R4", "zero-extended load data", loadData, expLoad);
    end
    @(posedge clk);
    #1;
    check(!(loadValid || storeDone || trapMisaligned || trapIllegal), "R9", "single response",
          {60'd0, loadValid, storeDone, trapMisaligned, trapIllegal}, 64'h0);
  endtask

  // Address ea reached from a chosen signed displacement
  task automatic reqAt(input logic [7:0] op, input logic [63:0] ea,
                       input logic [15:0] off, input logic [63:0] sdata);
    doReq(op, ea - {{48{off[15]}}, off}, off, sdata);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] ops [0:7];
    void'($urandom(32'd1234));
    ops[0] = 8'h71; ops[1] = 8'h69; ops[2] = 8'h61; ops[3] = 8'h79;
    ops[4] = 8'h73; ops[5] = 8'h6b; ops[6] = 8'h63; ops[7] = 8'h7b;
    for (int i = 0; i < 256; i++) begin
      ram[i] = 8'(i * 37 + 11);
      shadow[i] = 8'(i * 37 + 11);
    end
    repeat (3) @(posedge clk);
    #1;
    check(!(memEn || loadValid || storeDone || trapMisaligned || trapIllegal), "R9", "reset quiet",
          {59'd0, memEn, loadValid, storeDone, trapMisaligned, trapIllegal}, 64'h0);
    @(negedge clk);
    rstN = 1'b1;

    // Directed: each width, load after store, zero extension (R1 R2 R4 R5)
    reqAt(8'h7b, 64'd16, 16'd0, 64'hF1E2D3C4B5A69788);
    reqAt(8'h79, 64'd16, 16'd8, 64'd0);
    reqAt(8'h71, 64'd23, 16'hFFFF, 64'd0);
    reqAt(8'h69, 64'd22, 16'd3, 64'd0);
    reqAt(8'h61, 64'd20, 16'd4, 64'd0);
    reqAt(8'h73, 64'd41, 16'd5, 64'hFFFF_FFFF_FFFF_FFAB);
    reqAt(8'h6b, 64'd46, 16'd0, 64'hFFFF_FFFF_FFFF_1234);
    reqAt(8'h63, 64'd52, 16'd0, 64'hDEAD_BEEF_CAFE_F00D);
    reqAt(8'h79, 64'd40, 16'd0, 64'd0);
    reqAt(8'h79, 64'd48, 16'd0, 64'd0);
    // Displacement extremes and wrap through zero (R3)
    doReq(8'h79, 64'd32768 + 64'd64, 16'h8000, 64'd0);
    doReq(8'h79, 64'hFFFF_FFFF_FFFF_8048, 16'h7FFF + 16'd1 - 16'd1, 64'd0);
    doReq(8'h71, 64'hFFFF_FFFF_FFFF_FFFF, 16'd5, 64'd0);
    // Every misalignment of each width (R6), byte never misaligned
    for (int a = 1; a < 8; a++) begin
      reqAt(8'h79, 64'(64 + a), 16'd0, 64'd0);
      reqAt(8'h7b, 64'(64 + a), 16'd0, 64'd0);
      if (a % 4 != 0) reqAt(8'h61, 64'(64 + a), 16'd0, 64'd0);
      if (a % 2 != 0) reqAt(8'h6b, 64'(64 + a), 16'd0, 64'd0);
      reqAt(8'h71, 64'(64 + a), 16'd0, 64'd0);
    end
    // Neighbouring illegal opcodes at aligned and misaligned addresses (R7)
    reqAt(8'h70, 64'd8, 16'd0, 64'd0);
    reqAt(8'h7a, 64'd9, 16'd0, 64'd0);
    reqAt(8'h62, 64'd0, 16'd0, 64'd0);
    reqAt(8'h95, 64'd3, 16'd0, 64'd0);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0]  op;
      logic [63:0] ea, sd;
      logic [15:0] off;
      int n;
      if ($urandom_range(0, 9) == 0) op = 8'($urandom);
      else op = ops[$urandom_range(0, 7)];
      n = opBytes(op);
      ea = 64'($urandom_range(0, 255));
      if (n > 1 && $urandom_range(0, 3) != 0) ea = ea & ~64'(n - 1);
      if (n > 1 && ea > 64'(256 - n)) ea = 64'(256 - n) & ~64'(n - 1);
      off = 16'($signed($urandom_range(0, 4095)) - 2048);
      if ($urandom_range(0, 7) == 0) off = 16'($urandom);
      sd = {$urandom, $urandom};
      reqAt(op, ea, off, sd);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule